// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Registers

This block sits on the device side of a mobile SDRAM command bus. On every rising clock edge it captures chip select, the three command strobes, the clock-enable pin, the data mask, the bank bits and the address bus. It then classifies the captured pattern into exactly one command. The result is a one-hot strobe vector with the bank, row and column fields that belong to that command, plus flags for auto-precharge, precharge of all banks, a reserved mode-register target, an unaccepted burst stop and ignored address bits.

The block holds the standard and extended mode registers, which are loaded by the mode-set command. It also tracks whether a terminable burst is running, using the burst-length code in the standard mode register. It keeps a low-power flag after deep power-down or self-refresh entry. Finally, it delays the data-mask pin through a short pipeline to gate the read output driver, and presents the unpipelined mask as the write mask for the current cycle.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Synchronous reset leaves the strobe vector showing DESELECT (bit 0), both mode registers at zero, every flag low, all fields zero and readOe high.
- R2: Outputs reflect the pins captured at the most recent rising edge. Chip select high gives DESELECT whatever the other pins hold. With chip select low, {rasN,casN,weN} decodes as: 111 NOP (bit 1), 011 ACTIVE (bit 2), 101 READ (bit 3), 100 WRITE (bit 4), 010 PRECHARGE (bit 7), 000 MODE SET (bit 10). At most one strobe bit is high.
- R3: ACTIVE drives bankOut from ba and rowOut from addr[12:0]. Fields that do not belong to the current command read zero.
- R4: READ and WRITE drive colOut from addr[8:0] and bankOut from ba, and raise autoPre exactly when addr[10] is high.
- R5: Pattern 110 gives BURST STOP (bit 5) with cke high and DEEP POWER-DOWN entry (bit 6) with cke low. Pattern 001 gives AUTO REFRESH (bit 8) with cke high and SELF REFRESH entry (bit 9) with cke low.
- R6: PRECHARGE with addr[10] high raises preAll and reports bankOut as zero. With addr[10] low it reports the bank from ba and preAll stays low.
- R7: MODE SET with ba=00 loads addr into modeStd, and with ba=10 loads addr into modeExt, the new value showing one cycle after the command. Any other ba raises mrsReserved and leaves both registers unchanged.
- R8: BURST STOP is accepted only while a burst opened by a READ or WRITE without auto-precharge is still running. modeStd[2:0] gives the burst length: 0→1, 1→2, 2→4, 3→8, 7→open-ended, other codes→1. A burst of length L can be stopped in the L-1 cycles that follow its command. An unaccepted stop leaves all strobe bits low and raises illegalCmd. An accepted stop, a PRECHARGE, or a READ/WRITE with auto-precharge ends the burst.
- R9: lowPower rises the cycle after a DEEP POWER-DOWN or SELF REFRESH entry. It falls the cycle after a cycle whose captured cke is high.
- R10: readOe is the inverse of dqm as captured two edges earlier. writeMask equals dqm captured at the latest edge.
- R11: Refresh commands (bits 8 and 9) raise addrIgnored and report bank, row and column as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge sampling |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| cmdStrobe | output | 11 | One-hot decoded command |
| bankOut | output | 2 | Bank field of the command |
| rowOut | output | 13 | Row field (ACTIVE) |
| colOut | output | 9 | Column field (READ/WRITE) |
| autoPre | output | 1 | Auto-precharge requested |
| preAll | output | 1 | Precharge of every bank |
| mrsReserved | output | 1 | Mode set to a reserved target |
| illegalCmd | output | 1 | Burst stop outside a terminable burst |
| addrIgnored | output | 1 | Address bits are don't-care |
| lowPower | output | 1 | Deep power-down or self refresh entered |
| modeStd | output | 13 | Standard mode register |
| modeExt | output | 13 | Extended mode register |
| readOe | output | 1 | Read output driver enable |
| writeMask | output | 1 | Write data mask for this cycle |

## Verification
The bench builds the block with its default widths: a 13-bit row, a 9-bit column, two bank bits and a two-stage mask pipeline. It also uses a 4-bit burst counter. These defaults let random mode-set commands reach all eight burst-length codes, including the open-ended one and the codes that fall back to length one. So burst stops land both inside and outside live bursts. The two-stage pipeline lets mask pulses of one or more cycles be checked against the exact edge where readOe drops and recovers.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int CMD_N      = 11;
  localparam int CMD_DESEL  = 0;
  localparam int CMD_NOP    = 1;
  localparam int CMD_ACT    = 2;
  localparam int CMD_READ   = 3;
  localparam int CMD_WRITE  = 4;
  localparam int CMD_BST    = 5;
  localparam int CMD_DPD    = 6;
  localparam int CMD_PRE    = 7;
  localparam int CMD_AREF   = 8;
  localparam int CMD_SREF   = 9;
  localparam int CMD_MODE   = 10;

  localparam int AP_BIT     = 10;
  localparam int BL_FIELD_W = 3;

  typedef struct packed {
    logic selRow;
    logic selCol;
    logic selBank;
    logic loadStd;
    logic loadExt;
  } fieldSel_t;

  // Cycles after the command in which the burst is still running.
  function automatic int burstRemain(input logic [BL_FIELD_W-1:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 3;
      3'd3:    return 7;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic                  regA10,
  input  logic [BANK_W-1:0]     regBa,
  input  logic [BL_FIELD_W-1:0] blCode,
  output logic [CMD_N-1:0]      cmdStrobe,
  output fieldSel_t             sel,
  output logic                  autoPre,
  output logic                  preAll,
  output logic                  mrsReserved,
  output logic                  illegalCmd,
  output logic                  addrIgnored,
  output logic                  lowPower
);

  localparam logic [BANK_W-1:0] BA_STD = BANK_W'(0);
  localparam logic [BANK_W-1:0] BA_EXT = BANK_W'(2);

  logic regCke, regCsN, regRasN, regCasN, regWeN;
  logic [CNT_W-1:0] burstLeft;
  logic fullPage;
  logic burstActive;
  logic rwOpen;
  logic burstKill;

  always_ff @(posedge clk) begin
    if (rst) begin
      regCke  <= 1'b0;
      regCsN  <= 1'b1;
      regRasN <= 1'b1;
      regCasN <= 1'b1;
      regWeN  <= 1'b1;
    end else begin
      regCke  <= cke;
      regCsN  <= csN;
      regRasN <= rasN;
      regCasN <= casN;
      regWeN  <= weN;
    end
  end

  assign burstActive = (burstLeft != '0) || fullPage;

  always_comb begin
    cmdStrobe   = '0;
    sel         = '0;
    autoPre     = 1'b0;
    preAll      = 1'b0;
    mrsReserved = 1'b0;
    illegalCmd  = 1'b0;
    addrIgnored = 1'b0;
    if (regCsN) begin
      cmdStrobe[CMD_DESEL] = 1'b1;
    end else begin
      case ({regRasN, regCasN, regWeN})
        3'b111: cmdStrobe[CMD_NOP] = 1'b1;
        3'b011: begin
          cmdStrobe[CMD_ACT] = 1'b1;
          sel.selRow  = 1'b1;
          sel.selBank = 1'b1;
        end
        3'b101: begin
          cmdStrobe[CMD_READ] = 1'b1;
          sel.selCol  = 1'b1;
          sel.selBank = 1'b1;
          autoPre     = regA10;
        end
        3'b100: begin
          cmdStrobe[CMD_WRITE] = 1'b1;
          sel.selCol  = 1'b1;
          sel.selBank = 1'b1;
          autoPre     = regA10;
        end
        3'b110: begin
          if (!regCke)          cmdStrobe[CMD_DPD] = 1'b1;
          else if (burstActive) cmdStrobe[CMD_BST] = 1'b1;
          else                  illegalCmd         = 1'b1;
        end
        3'b010: begin
          cmdStrobe[CMD_PRE] = 1'b1;
          preAll      = regA10;
          sel.selBank = !regA10;
        end
        3'b001: begin
          addrIgnored = 1'b1;
          if (regCke) cmdStrobe[CMD_AREF] = 1'b1;
          else        cmdStrobe[CMD_SREF] = 1'b1;
        end
        default: begin
          cmdStrobe[CMD_MODE] = 1'b1;
          if (regBa == BA_STD)      sel.loadStd = 1'b1;
          else if (regBa == BA_EXT) sel.loadExt = 1'b1;
          else                      mrsReserved = 1'b1;
        end
      endcase
    end
  end

  assign rwOpen    = (cmdStrobe[CMD_READ] | cmdStrobe[CMD_WRITE]) & ~regA10;
  assign burstKill = cmdStrobe[CMD_BST] | cmdStrobe[CMD_PRE]
                   | ((cmdStrobe[CMD_READ] | cmdStrobe[CMD_WRITE]) & regA10);

  always_ff @(posedge clk) begin
    if (rst) begin
      burstLeft <= '0;
      fullPage  <= 1'b0;
    end else if (rwOpen) begin
      burstLeft <= CNT_W'(burstRemain(blCode));
      fullPage  <= (blCode == 3'b111);
    end else if (burstKill) begin
      burstLeft <= '0;
      fullPage  <= 1'b0;
    end else if (burstLeft != '0) begin
      burstLeft <= burstLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                        lowPower <= 1'b0;
    else if (cmdStrobe[CMD_DPD] | cmdStrobe[CMD_SREF]) lowPower <= 1'b1;
    else if (regCke)                                lowPower <= 1'b0;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmdStrobe)) else $error("multiple strobes"); // R2

  AST_BURST_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmdStrobe[CMD_READ] && !autoPre && blCode == 3'b010) |=> burstActive)
    else $error("burst not opened"); // R8

  AST_ILLEGAL_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    illegalCmd |-> (cmdStrobe == '0 && regCke)) else $error("illegal stop"); // R8

  AST_LP_SET: assert property (@(posedge clk) disable iff (rst)
    (cmdStrobe[CMD_DPD] || cmdStrobe[CMD_SREF]) |=> lowPower)
    else $error("low power not set"); // R9

  AST_LP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (regCke && !cmdStrobe[CMD_SREF]) |=> !lowPower)
    else $error("low power not cleared"); // R9

endmodule

// File: rtl/sdram_cmd_datapath.sv
module sdram_cmd_datapath
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int DQM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] ba,
  input  logic              dqm,
  input  fieldSel_t         sel,
  output logic              regA10,
  output logic [BANK_W-1:0] regBa,
  output logic [BANK_W-1:0] bankOut,
  output logic [ROW_W-1:0]  rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic [ROW_W-1:0]  modeStd,
  output logic [ROW_W-1:0]  modeExt,
  output logic              readOe,
  output logic              writeMask
);

  logic [ROW_W-1:0]   regAddr;
  logic               regDqm;
  logic [DQM_LAT-1:0] dqmPipe;
  logic [1:0]         warmCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      regAddr <= '0;
      regBa   <= '0;
      regDqm  <= 1'b0;
    end else begin
      regAddr <= addr;
      regBa   <= ba;
      regDqm  <= dqm;
    end
  end

  assign regA10  = regAddr[AP_BIT];
  assign bankOut = sel.selBank ? regBa : '0;
  assign rowOut  = sel.selRow  ? regAddr : '0;
  assign colOut  = sel.selCol  ? regAddr[COL_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeStd <= '0;
      modeExt <= '0;
    end else begin
      if (sel.loadStd) modeStd <= regAddr;
      if (sel.loadExt) modeExt <= regAddr;
    end
  end

  generate
    if (DQM_LAT == 1) begin : g_pipe1
      always_ff @(posedge clk) begin
        if (rst) dqmPipe <= '0;
        else     dqmPipe <= regDqm;
      end
    end else begin : g_pipeN
      always_ff @(posedge clk) begin
        if (rst) dqmPipe <= '0;
        else     dqmPipe <= {dqmPipe[DQM_LAT-2:0], regDqm};
      end
    end
  endgenerate

  assign readOe    = ~dqmPipe[DQM_LAT-1];
  assign writeMask = regDqm;

  always_ff @(posedge clk) begin
    if (rst)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  AST_STD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sel.loadStd && warmCnt != 2'd0) |=> $stable(modeStd))
    else $error("std mode changed"); // R7

  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
    sel.loadExt |=> (modeExt == $past(regAddr))) else $error("ext load"); // R7

  AST_BANK_GATED: assert property (@(posedge clk) disable iff (rst)
    (!sel.selBank) |-> (bankOut == '0)) else $error("bank leak"); // R6

  generate
    if (DQM_LAT == 2) begin : g_oeChk
      AST_OE_LAG: assert property (@(posedge clk) disable iff (rst)
        (warmCnt == 2'd3) |-> (readOe == !$past(regDqm, 2)))
        else $error("oe lag"); // R10
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int DQM_LAT = 2,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              dqm,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [CMD_N-1:0]  cmdStrobe,
  output logic [BANK_W-1:0] bankOut,
  output logic [ROW_W-1:0]  rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic              autoPre,
  output logic              preAll,
  output logic              mrsReserved,
  output logic              illegalCmd,
  output logic              addrIgnored,
  output logic              lowPower,
  output logic [ROW_W-1:0]  modeStd,
  output logic [ROW_W-1:0]  modeExt,
  output logic              readOe,
  output logic              writeMask
);

  fieldSel_t         sel;
  logic              regA10;
  logic [BANK_W-1:0] regBa;

  sdram_cmd_ctrl #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .regA10(regA10), .regBa(regBa),
    .blCode(modeStd[BL_FIELD_W-1:0]), .cmdStrobe(cmdStrobe), .sel(sel),
    .autoPre(autoPre), .preAll(preAll), .mrsReserved(mrsReserved),
    .illegalCmd(illegalCmd), .addrIgnored(addrIgnored), .lowPower(lowPower)
  );

  sdram_cmd_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
                       .DQM_LAT(DQM_LAT)) u_data (
    .clk(clk), .rst(rst), .addr(addr), .ba(ba), .dqm(dqm), .sel(sel),
    .regA10(regA10), .regBa(regBa), .bankOut(bankOut), .rowOut(rowOut),
    .colOut(colOut), .modeStd(modeStd), .modeExt(modeExt),
    .readOe(readOe), .writeMask(writeMask)
  );

endmodule

// File: tb/sim_sdram_cmd_decoder.sv
`timescale 1ns/1ps
module sim_sdram_cmd_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b0, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, dqm = 1'b0;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [10:0] cmdStrobe;
  logic [1:0] bankOut;
  logic [12:0] rowOut;
  logic [8:0] colOut;
  logic autoPre, preAll, mrsReserved, illegalCmd, addrIgnored, lowPower;
  logic [12:0] modeStd, modeExt;
  logic readOe, writeMask;

  always #2 clk = ~clk;

  sdram_cmd_decoder u0 (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dqm(dqm), .ba(ba), .addr(addr), .cmdStrobe(cmdStrobe),
    .bankOut(bankOut), .rowOut(rowOut), .colOut(colOut), .autoPre(autoPre),
    .preAll(preAll), .mrsReserved(mrsReserved), .illegalCmd(illegalCmd),
    .addrIgnored(addrIgnored), .lowPower(lowPower), .modeStd(modeStd),
    .modeExt(modeExt), .readOe(readOe), .writeMask(writeMask)
  );

  int nChecks = 0;
  int nFail = 0;

  // reference state
  logic [12:0] mStd = '0, mExt = '0;
  int mLeft = 0;
  bit mFull = 0, mLp = 0, mP0 = 0, mP1 = 0;
  // previous-cycle decode results
  bit pLoadStd = 0, pLoadExt = 0, pOpen = 0, pKill = 0, pEntry = 0, pCke = 0, pDqm = 0;
  logic [12:0] pAddr = '0;
  logic [2:0] pBl = '0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int remainOf(input logic [2:0] code);
    int len;
    case (code)
      3'd0: len = 1;
      3'd1: len = 2;
      3'd2: len = 4;
      3'd3: len = 8;
      default: len = 1;
    endcase
    return len - 1;
  endfunction

  task automatic step(input bit iCke, input bit iCs, input bit iRas, input bit iCas,
                      input bit iWe, input bit iDqm, input logic [1:0] iBa,
                      input logic [12:0] iAddr);
    int eStrobe, eBank, eRow, eCol;
    bit eAp, ePa, eRsv, eIll, eIgn, active, a10;
    string tag;
    @(negedge clk);
    cke = iCke; csN = iCs; rasN = iRas; casN = iCas; weN = iWe; dqm = iDqm;
    ba = iBa; addr = iAddr;
    @(posedge clk);
    if (pLoadStd) mStd = pAddr;
    if (pLoadExt) mExt = pAddr;
    if (pOpen) begin mLeft = remainOf(pBl); mFull = (pBl == 3'd7); end
    else if (pKill) begin mLeft = 0; mFull = 0; end
    else if (mLeft != 0) mLeft--;
    if (pEntry) mLp = 1; else if (pCke) mLp = 0;
    mP1 = mP0; mP0 = pDqm;
    eStrobe = 0; eBank = 0; eRow = 0; eCol = 0;
    eAp = 0; ePa = 0; eRsv = 0; eIll = 0; eIgn = 0;
    pLoadStd = 0; pLoadExt = 0; pOpen = 0; pKill = 0; pEntry = 0;
    active = (mLeft != 0) || mFull;
    a10 = iAddr[10];
    tag = "R2";
    if (iCs) eStrobe = 1 << 0;
    else case ({iRas, iCas, iWe})
      3'b111: eStrobe = 1 << 1;
      3'b011: begin eStrobe = 1 << 2; eBank = iBa; eRow = iAddr; end
      3'b101, 3'b100: begin
        eStrobe = (iWe ? 1 << 3 : 1 << 4);
        eBank = iBa; eCol = iAddr[8:0]; eAp = a10;
        if (a10) pKill = 1; else pOpen = 1;
      end
      3'b110: begin
        tag = "R5";
        if (!iCke) begin eStrobe = 1 << 6; pEntry = 1; end
        else if (active) begin eStrobe = 1 << 5; pKill = 1; end
        else eIll = 1;
      end
      3'b010: begin
        eStrobe = 1 << 7; ePa = a10; eBank = a10 ? 0 : iBa; pKill = 1;
      end
      3'b001: begin
        tag = "R5"; eIgn = 1;
        if (iCke) eStrobe = 1 << 8;
        else begin eStrobe = 1 << 9; pEntry = 1; end
      end
      default: begin
        eStrobe = 1 << 10;
        if (iBa == 2'b00) pLoadStd = 1;
        else if (iBa == 2'b10) pLoadExt = 1;
        else eRsv = 1;
      end
    endcase
    pBl = mStd[2:0]; pAddr = iAddr; pCke = iCke; pDqm = iDqm;
    #1;
    chk(tag, cmdStrobe, eStrobe);
    chk("R3", bankOut, eBank);
    chk("R3", rowOut, eRow);
    chk("R4", colOut, eCol);
    chk("R4", autoPre, eAp);
    chk("R6", preAll, ePa);
    chk("R7", mrsReserved, eRsv);
    chk("R7", modeStd, mStd);
    chk("R7", modeExt, mExt);
    chk("R8", illegalCmd, eIll);
    chk("R11", addrIgnored, eIgn);
    chk("R9", lowPower, mLp);
    chk("R10", readOe, !mP1);
    chk("R10", writeMask, iDqm);
  endtask

  task automatic nop(input bit iCke, input bit iDqm);
    step(iCke, 0, 1, 1, 1, iDqm, 2'b00, 13'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired R1 act=0 exp=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int unsigned seedVal = 32'd20240611;
    int unsigned r;
    r = $urandom(seedVal);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", cmdStrobe, 1);
    chk("R1", modeStd, 0);
    chk("R1", modeExt, 0);
    chk("R1", readOe, 1);
    chk("R1", lowPower, 0);
    chk("R1", illegalCmd, 0);
    @(negedge clk);
    rst = 1'b0;

    // R7: standard mode set, burst length 4
    step(1, 0, 0, 0, 0, 0, 2'b00, 13'h0002);
    chk("R7", cmdStrobe, 1 << 10);
    nop(1, 0);
    chk("R7", modeStd, 13'h0002);
    // R4: read without auto-precharge
    step(1, 0, 1, 0, 1, 0, 2'b01, 13'h01A5);
    chk("R4", colOut, 9'h1A5);
    chk("R4", autoPre, 0);
    // R8: accepted stop, then rejected stop
    step(1, 0, 1, 1, 0, 0, 2'b00, 13'h0);
    chk("R8", cmdStrobe, 1 << 5);
    step(1, 0, 1, 1, 0, 0, 2'b00, 13'h0);
    chk("R8", illegalCmd, 1);
    chk("R8", cmdStrobe, 0);
    // R7: reserved target leaves registers alone
    step(1, 0, 0, 0, 0, 0, 2'b01, 13'h1FFF);
    chk("R7", mrsReserved, 1);
    nop(1, 0);
    chk("R7", modeStd, 13'h0002);
    chk("R7", modeExt, 0);
    step(1, 0, 0, 0, 0, 0, 2'b10, 13'h1555);
    nop(1, 0);
    chk("R7", modeExt, 13'h1555);
    // R6: precharge all
    step(1, 0, 0, 1, 0, 0, 2'b11, 13'h0400);
    chk("R6", preAll, 1);
    chk("R6", bankOut, 0);
    // R3: activate
    step(1, 0, 0, 1, 1, 0, 2'b10, 13'h1ABC);
    chk("R3", rowOut, 13'h1ABC);
    chk("R3", bankOut, 2);
    // R11: refresh ignores address
    step(1, 0, 0, 0, 1, 0, 2'b11, 13'h1FFF);
    chk("R11", addrIgnored, 1);
    chk("R5", cmdStrobe, 1 << 8);
    chk("R11", rowOut, 0);
    // R5/R9: deep power-down and exit
    step(0, 0, 1, 1, 0, 0, 2'b00, 13'h0);
    chk("R5", cmdStrobe, 1 << 6);
    nop(0, 0);
    chk("R9", lowPower, 1);
    nop(1, 0);
    chk("R9", lowPower, 1);
    nop(1, 0);
    chk("R9", lowPower, 0);
    // R10: mask pulse
    nop(1, 1);
    chk("R10", writeMask, 1);
    chk("R10", readOe, 1);
    nop(1, 0);
    chk("R10", readOe, 1);
    nop(1, 0);
    chk("R10", readOe, 0);
    nop(1, 0);
    chk("R10", readOe, 1);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit rc, rcs, rdq;
      logic [2:0] rcmd;
      rc   = ($urandom % 10) < 7;
      rcs  = ($urandom % 100) < 12;
      rdq  = ($urandom % 10) < 2;
      rcmd = 3'($urandom);
      step(rc, rcs, rcmd[2], rcmd[1], rcmd[0], rdq, 2'($urandom), 13'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule